// File: doc/BRIEF.md
# GPIO Port Configuration Register Bank

This block holds the configuration of one general-purpose I/O port of up to 32 pins. It sits behind a simple 32-bit read/write bus. It owns seven configuration registers: output data, interrupt mask, pull control, function enable, function select, direction and trigger. It also has one read-only register that returns the synchronized pin levels. Each configuration register answers at three addresses. A plain address loads and reads the whole word. A set alias ORs the written ones into the register. A clear alias removes the written ones. Firmware can therefore change one pin with a single write and needs no read-modify-write.

From the register contents the block drives the pad controls for each pin: output enable, output value, pull-up enable and a 2-bit alternate-function code. It also passes to the interrupt detector outside the block the mask for each pin, the edge/level choice and the polarity. The polarity comes from the direction register. Reads go through a two-state bus FSM, `ST_IDLE` and `ST_RESP`. A read strobe in either state moves the FSM to `ST_RESP` on the next edge, and that state presents the data. The FSM moves from `ST_RESP` back to `ST_IDLE` when no read strobe is present. `ST_RESP` also follows itself on back-to-back reads.

A port can be built with fewer implemented pins than the bus width. The bits above the implemented count read as zero, ignore writes and drive zero.

Top module: `gpio_port_regbank`

## Requirements
- R1: After reset the output-data, function, select, direction and trigger registers read zero. The mask and pull registers read ones in every implemented bit. `bus_rvalid` is 0.
- R2: Register word addresses are: pin level 0x00, data 0x10, mask 0x20, pull 0x30, function 0x40, select 0x50, direction 0x60, trigger 0x70. A write to one of these addresses loads the whole word. A read strobe at an address returns that register on `bus_rdata` with `bus_rvalid` high in the cycle after the strobe.
- R3: A write to base+0x4 sets each register bit whose write bit is one and leaves every other bit unchanged.
- R4: A write to base+0x8 clears each register bit whose write bit is one and leaves every other bit unchanged.
- R5: Direction bit 1 means output. `pin_oe` is high only where direction is 1 and function is 0. `pin_out` equals the data register.
- R6: The pull register is active-low. `pin_pull_en` is high exactly where an implemented pull bit is 0.
- R7: `pin_func[2i+1:2i]` is 0 when function bit i is 0, whatever select and trigger hold. With function 1 the code is 1 when select is 0, 2 when select is 1 and trigger is 0, and 3 when both are 1.
- R8: Bits at or above `PIN_COUNT` read zero, ignore every kind of write and drive zero on all per-pin outputs.
- R9: The pin-level register returns `pin_in` through a two-flop synchronizer. A read picks up a new level only when the level was applied at least two clock edges before the read's own edge.
- R10: A read of a set or clear alias, or of any unmapped address, returns zero. Writes to 0x00, 0x04, 0x08, to offsets 0xC of a register, or to addresses above 0x7C change no register.
- R11: `irq_mask` equals the mask register. `irq_high` equals the direction register. `irq_edge` is the trigger register gated to pins whose function bit is 0.
- R12: `bus_rvalid` is high in the cycle after a read strobe and low in the cycle after a cycle without one. `bus_rdata` is zero whenever `bus_rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data, valid the cycle after the strobe |
| bus_rvalid | output | 1 | High while read data is presented |
| pin_in | input | PORT_W | Raw pin levels from the pads |
| pin_oe | output | PORT_W | Output enable per pin |
| pin_out | output | PORT_W | Output value per pin |
| pin_pull_en | output | PORT_W | Pull-up enable per pin, active high |
| pin_func | output | 2*PORT_W | Alternate-function code, two bits per pin |
| irq_mask | output | PORT_W | Interrupt mask per pin, 1 = masked |
| irq_edge | output | PORT_W | 1 = edge detection, 0 = level detection |
| irq_high | output | PORT_W | 1 = rising/high polarity, 0 = falling/low |

## Verification
Writes change the registers at the next clock edge, and the pad and interrupt outputs decode straight from the registers. The bench therefore samples them at the falling edge right after the write's rising edge. Read data is registered, so a read driven before edge N is checked just after edge N. A pin level change takes two edges through the synchronizer and one more into the read register. The bench issues reads one, two and three edges after changing `pin_in` and expects the old value, the old value and then the new value.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LOAD = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } wr_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

    localparam int NUM_CFG  = 7;
    localparam int IDX_PIN  = 0;
    localparam int IDX_DATA = 1;
    localparam int IDX_MASK = 2;
    localparam int IDX_PULL = 3;
    localparam int IDX_FUNC = 4;
    localparam int IDX_SEL  = 5;
    localparam int IDX_DIR  = 6;
    localparam int IDX_TRIG = 7;

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
    import gpio_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CFG:0]  hit,
    output wr_op_e            op
);
    localparam int IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0] idx;
    logic [3:0]       sub;

    assign idx = addr[ADDR_W-1:4];
    assign sub = addr[3:0];

    always_comb begin
        hit = '0;
        for (int k = 0; k <= NUM_CFG; k++) begin
            hit[k] = (idx == IDX_W'(k));
        end
    end

    always_comb begin
        unique case (sub)
            4'h0:    op = OP_LOAD;
            4'h4:    op = OP_SET;
            4'h8:    op = OP_CLR;
            default: op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_rb_cfgreg.sv
module gpio_rb_cfgreg
    import gpio_rb_pkg::*;
#(
    parameter int              W    = 32,
    parameter logic [W-1:0]    IMPL = '1,
    parameter logic [W-1:0]    RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  wr_op_e       op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= RST & IMPL;
        end else if (we) begin
            unique case (op)
                OP_LOAD: q <= wdata & IMPL;
                OP_SET:  q <= q | (wdata & IMPL);
                OP_CLR:  q <= q & ~wdata;
                default: q <= q;
            endcase
        end
    end
endmodule

// File: rtl/gpio_rb_sync.sv
module gpio_rb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_port_regbank.sv
module gpio_port_regbank
    import gpio_rb_pkg::*;
#(
    parameter int PORT_W    = 32,
    parameter int PIN_COUNT = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [PORT_W-1:0]   bus_wdata,
    output logic [PORT_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [PORT_W-1:0]   pin_in,
    output logic [PORT_W-1:0]   pin_oe,
    output logic [PORT_W-1:0]   pin_out,
    output logic [PORT_W-1:0]   pin_pull_en,
    output logic [2*PORT_W-1:0] pin_func,
    output logic [PORT_W-1:0]   irq_mask,
    output logic [PORT_W-1:0]   irq_edge,
    output logic [PORT_W-1:0]   irq_high
);
    function automatic logic [PORT_W-1:0] impl_f();
        logic [PORT_W-1:0] r;
        for (int i = 0; i < PORT_W; i++) r[i] = (i < PIN_COUNT);
        return r;
    endfunction

    localparam logic [PORT_W-1:0] IMPL = impl_f();

    logic [NUM_CFG:0]  hit;
    wr_op_e            op;
    logic [PORT_W-1:0] cfg_q [NUM_CFG:1];
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] rd_mux;
    bus_state_e        st, st_nx;

    gpio_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit),
        .op   (op)
    );

    gpio_rb_sync #(.W(PORT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    for (genvar k = 1; k <= NUM_CFG; k++) begin : g_cfg
        localparam logic [PORT_W-1:0] RSTV =
            (k == IDX_MASK || k == IDX_PULL) ? '1 : '0;
        gpio_rb_cfgreg #(.W(PORT_W), .IMPL(IMPL), .RST(RSTV)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr_en & hit[k]),
            .op    (op),
            .wdata (bus_wdata),
            .q     (cfg_q[k])
        );
    end

    // Read mux: only the plain address of a register returns data
    always_comb begin
        rd_mux = '0;
        if (op == OP_LOAD) begin
            if (hit[IDX_PIN]) rd_mux = pin_sync & IMPL;
            for (int k = 1; k <= NUM_CFG; k++) begin
                if (hit[k]) rd_mux = rd_mux | cfg_q[k];
            end
        end
    end

    // Bus FSM: next state
    always_comb begin
        unique case (st)
            ST_IDLE: st_nx = bus_rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: st_nx = bus_rd_en ? ST_RESP : ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Bus FSM: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
        else                bus_rdata <= '0;
    end

    assign bus_rvalid = (st == ST_RESP);

    // Pad and interrupt controls
    assign pin_oe      = cfg_q[IDX_DIR] & ~cfg_q[IDX_FUNC];
    assign pin_out     = cfg_q[IDX_DATA];
    assign pin_pull_en = ~cfg_q[IDX_PULL] & IMPL;
    assign irq_mask    = cfg_q[IDX_MASK];
    assign irq_high    = cfg_q[IDX_DIR];
    assign irq_edge    = cfg_q[IDX_TRIG] & ~cfg_q[IDX_FUNC];

    for (genvar i = 0; i < PORT_W; i++) begin : g_func
        assign pin_func[2*i +: 2] =
            !cfg_q[IDX_FUNC][i] ? 2'd0 :
            !cfg_q[IDX_SEL][i]  ? 2'd1 :
             cfg_q[IDX_TRIG][i] ? 2'd3 : 2'd2;
    end
endmodule

// File: rtl/gpio_port_regbank_chk.sv
module gpio_port_regbank_chk #(
    parameter int PORT_W    = 32,
    parameter int PIN_COUNT = 32,
    parameter int ADDR_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr_en,
    input logic                bus_rd_en,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [PORT_W-1:0]   bus_wdata,
    input logic [PORT_W-1:0]   bus_rdata,
    input logic                bus_rvalid,
    input logic [PORT_W-1:0]   pin_oe,
    input logic [PORT_W-1:0]   pin_out,
    input logic [2*PORT_W-1:0] pin_func
);
    function automatic logic [PORT_W-1:0] impl_f();
        logic [PORT_W-1:0] r;
        for (int i = 0; i < PORT_W; i++) r[i] = (i < PIN_COUNT);
        return r;
    endfunction

    localparam logic [PORT_W-1:0] IMPL = impl_f();

    logic [PORT_W-1:0] fnz;
    always_comb begin
        for (int i = 0; i < PORT_W; i++) fnz[i] = |pin_func[2*i +: 2];
    end

    AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_en |=> bus_rvalid); // R12
    AST_NO_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> (!bus_rvalid && bus_rdata == '0)); // R12
    AST_SET_ALIAS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(8'h14))
        |=> pin_out == ($past(pin_out) | ($past(bus_wdata) & IMPL))); // R3
    AST_CLR_ALIAS_AND: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'(8'h18))
        |=> pin_out == ($past(pin_out) & ~$past(bus_wdata))); // R4
    AST_OE_GPIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & fnz) == '0); // R5
    AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out | fnz) & ~IMPL) == '0); // R8
    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr[3:0] != 4'h0) |=> bus_rdata == '0); // R10
endmodule

bind gpio_port_regbank gpio_port_regbank_chk #(
    .PORT_W(PORT_W), .PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .pin_func   (pin_func)
);

// File: tb/gpio_port_regbank_tb.sv
module gpio_port_regbank_tb;
    localparam int PW = 32;
    localparam logic [31:0] IMPL = 32'h7FFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [31:0]   pin_in = '0;
    logic [31:0]   pin_oe, pin_out, pin_pull_en, irq_mask, irq_edge, irq_high;
    logic [63:0]   pin_func;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    gpio_port_regbank #(.PORT_W(PW), .PIN_COUNT(31), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pull_en(pin_pull_en), .pin_func(pin_func),
        .irq_mask(irq_mask), .irq_edge(irq_edge), .irq_high(irq_high)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks are entered and left just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; v = bus_rvalid;
        bus_rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic v;
        rd(a, d, v);
        chk({tag, " rvalid"}, 64'(v), 64'd1);
        chk(tag, 64'(d), 64'(exp));
    endtask

    task automatic t_reset;
        chk("R1 idle rvalid", 64'(bus_rvalid), 64'd0);
        rd_chk("R1 data", 8'h10, 32'h0);
        rd_chk("R1 mask", 8'h20, IMPL);
        rd_chk("R1 pull", 8'h30, IMPL);
        rd_chk("R1 func", 8'h40, 32'h0);
        rd_chk("R1 sel", 8'h50, 32'h0);
        rd_chk("R1 dir", 8'h60, 32'h0);
        rd_chk("R1 trig", 8'h70, 32'h0);
        chk("R1 pin_oe", 64'(pin_oe), 64'd0);
        chk("R1 pin_pull_en", 64'(pin_pull_en), 64'd0);
    endtask

    task automatic t_plain;
        wr(8'h10, 32'hA5A5_1234);
        chk("R2 pin_out after load", 64'(pin_out), 64'h25A5_1234);
        rd_chk("R2 data readback", 8'h10, 32'h25A5_1234);
    endtask

    task automatic t_set_clear;
        wr(8'h64, 32'h0000_00F0);
        wr(8'h64, 32'h0000_000F);
        rd_chk("R3 dir set accumulate", 8'h60, 32'h0000_00FF);
        wr(8'h68, 32'h0000_003C);
        rd_chk("R4 dir clear", 8'h60, 32'h0000_00C3);
        chk("R5 pin_oe gpio", 64'(pin_oe), 64'h0000_00C3);
        wr(8'h18, 32'h0000_1230);
        chk("R4 data clear pin_out", 64'(pin_out), 64'h25A5_0004);
        wr(8'h14, 32'h0000_0003);
        chk("R3 data set pin_out", 64'(pin_out), 64'h25A5_0007);
    endtask

    task automatic t_pull;
        wr(8'h38, 32'h0000_0005);
        rd_chk("R6 pull reg", 8'h30, 32'h7FFF_FFFA);
        chk("R6 pull_en", 64'(pin_pull_en), 64'h0000_0005);
        wr(8'h34, 32'h0000_0001);
        chk("R6 pull disabled again", 64'(pin_pull_en), 64'h0000_0004);
    endtask

    task automatic t_func;
        wr(8'h44, 32'h0000_000E);
        wr(8'h54, 32'h0000_000C);
        wr(8'h74, 32'h0000_0009);
        chk("R7 func codes", 64'(pin_func[7:0]), 64'hE4);
        chk("R5 oe gated by func", 64'(pin_oe), 64'h0000_00C1);
        chk("R11 irq_edge gpio only", 64'(irq_edge), 64'h0000_0001);
        chk("R11 irq_high", 64'(irq_high), 64'h0000_00C3);
    endtask

    task automatic t_unimpl;
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R8 data bit31 zero", 8'h10, IMPL);
        chk("R8 pin_out bit31", 64'(pin_out), 64'(IMPL));
        wr(8'h64, 32'h8000_0000);
        rd_chk("R8 dir bit31 ignored", 8'h60, 32'h0000_00C3);
    endtask

    task automatic t_ignore;
        wr(8'h00, 32'h0000_FFFF);
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0000_0000);
        wr(8'h68, 32'h0000_0000);
        wr(8'h80, 32'h0000_0000);
        wr(8'hF8, 32'hFFFF_FFFF);
        rd_chk("R10 data untouched", 8'h10, IMPL);
        rd_chk("R10 dir untouched", 8'h60, 32'h0000_00C3);
        rd_chk("R10 set alias reads 0", 8'h14, 32'h0);
        rd_chk("R10 clear alias reads 0", 8'h28, 32'h0);
        rd_chk("R10 unmapped reads 0", 8'h80, 32'h0);
    endtask

    task automatic t_irq;
        wr(8'h28, 32'h0000_0003);
        chk("R11 irq_mask", 64'(irq_mask), 64'h7FFF_FFFC);
        rd_chk("R11 mask reg", 8'h20, 32'h7FFF_FFFC);
    endtask

    task automatic t_sync;
        pin_in = 32'h1234_5678;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R9 settled level", 8'h00, 32'h1234_5678);
        pin_in = 32'hFFFF_0000;
        rd_chk("R9 one edge old", 8'h00, 32'h1234_5678);
        rd_chk("R9 two edges old", 8'h00, 32'h1234_5678);
        rd_chk("R9 third edge new", 8'h00, 32'h7FFF_0000);
    endtask

    task automatic t_fsm;
        logic [31:0] d; logic v;
        @(negedge clk);
        chk("R12 rvalid low idle", 64'(bus_rvalid), 64'd0);
        chk("R12 rdata zero idle", 64'(bus_rdata), 64'd0);
        rd(8'h60, d, v);
        chk("R12 rvalid after strobe", 64'(v), 64'd1);
        @(negedge clk);
        chk("R12 back to idle", 64'(bus_rvalid), 64'd0);
    endtask

    initial begin
        #(200000 * 10);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_set_clear();
        t_pull();
        t_func();
        t_unimpl();
        t_ignore();
        t_irq();
        t_sync();
        t_fsm();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule